// File: doc/BRIEF.md
# Retriggerable Pulse-Activity Hold

This block watches a pulse train that is not tied to any clock and reports whether that train is still running. A free-running local clock, which stays alive after the pulses stop, provides all of the timing. The first rising edge of a pulse sets the output high. Every rising edge after that restarts a silence window. When a whole window goes by with no new rising edge, the output drops low. The block then waits for the next pulse and starts a fresh active period from it.

The output follows activity, not a fixed pulse length. While edges keep arriving faster than the window, the output stays high with no time limit, so runs of many hours are covered. The counter restarts on every edge and never counts past the window, so a long run cannot wrap it and clear the output by mistake.

Three parameters set the timing: the local clock rate, the window length in clock cycles, and the synchronizer depth. Elaboration stops with an error in three cases:
- the window is not strictly longer than 333 us;
- the window is not strictly shorter than 1 s;
- the latency from input edge to output exceeds 80 us.

Top module: `pulse_activity_hold`

## Requirements
- R1: While reset is asserted, and after reset for as long as no rising edge has appeared on the pulse input, the output is low.
- R2: A rising edge on the pulse input, launched just after clock edge n while the output is low, makes the output high from clock edge n+SYNC_STAGES+1 (edge n+3 with the default of two stages). Before that edge the output is still low.
- R3: Only rising edges matter. A pulse input held high does not retrigger anything, and the later falling edge changes nothing. The output falls TIMEOUT_CYCLES clock cycles after the edge at which the rise was registered, even if the input is still high at that point.
- R4: Every rising edge seen while the output is high restarts the window. The output then stays high until TIMEOUT_CYCLES cycles after the registration of the most recent edge.
- R5: When no new edge is registered, the output is high for exactly TIMEOUT_CYCLES clock cycles. With an edge launched after clock edge n, the output is still high at edge n+2+TIMEOUT_CYCLES and low from edge n+3+TIMEOUT_CYCLES.
- R6: If a new edge is registered on the same clock edge at which the window would expire, the new edge wins. The output stays high and a full new window starts.
- R7: A pulse train whose period is shorter than the window keeps the output high for any number of periods, with no spurious low cycle. The internal count never exceeds TIMEOUT_CYCLES-1.
- R8: After the output has cleared, the next rising edge starts a new high period with the same latency as in R2. This includes an edge that arrives one cycle after the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running local clock, the only timing reference |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | Pulse train, asynchronous to clk_i |
| active_o | output | 1 | High while pulse activity is present |

## Verification
Some properties are checked by assertions on every clock cycle:
- an edge registered while idle arms the output;
- every edge clears the count;
- the count advances by one while held and never passes the last window cycle;
- expiry without a new edge drops the output;
- a new edge on the expiry cycle keeps the output high;
- the edge detector never reports two rising edges in a row.

Other behaviour can only be shown by the bench scenarios, because it spans the whole path from the input pin to the output:
- the exact end-to-end latency through the synchronizer;
- a level held high for longer than the window;
- retrigger timing measured from the input pin;
- re-arming one cycle after a clear;
- a train of five hundred periods that never lets the output drop.

// File: rtl/pah_pkg.sv
package pah_pkg;

    typedef enum logic {
        HOLD_IDLE   = 1'b0,
        HOLD_ACTIVE = 1'b1
    } hold_e;

    localparam longint unsigned MICROS_PER_SEC  = 64'd1_000_000;
    localparam longint unsigned MIN_SILENCE_US  = 64'd333;
    localparam longint unsigned MAX_ARM_US      = 64'd80;

    function automatic longint unsigned us_to_cycles(input longint unsigned hz,
                                                     input longint unsigned us);
        return (hz * us) / MICROS_PER_SEC;
    endfunction

endpackage

// File: rtl/pah_sync.sv
module pah_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign chain_d[i] = async_i;
        end else begin : g_next
            assign chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pah_edge.sv
module pah_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic rise_o
);

    logic prev_d;
    logic prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign rise_o = level_i & ~prev_q;

    // R3
    single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pah_silence_timer.sv
module pah_silence_timer
    import pah_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 500
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_i,
    output logic hold_o
);

    localparam int unsigned CW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

    typedef struct packed {
        hold_e         state;
        logic [CW-1:0] count;
    } timer_s;

    timer_s tmr_d;
    timer_s tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (rise_i) begin
            tmr_d.state = HOLD_ACTIVE;
            tmr_d.count = '0;
        end else if (tmr_q.state == HOLD_ACTIVE) begin
            if (tmr_q.count == LAST) begin
                tmr_d.state = HOLD_IDLE;
                tmr_d.count = '0;
            end else begin
                tmr_d.count = tmr_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '{state: HOLD_IDLE, count: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign hold_o = (tmr_q.state == HOLD_ACTIVE);

    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmr_q.state == HOLD_IDLE && !rise_i) |=> tmr_q.state == HOLD_IDLE);

    // R2
    idle_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmr_q.state == HOLD_IDLE && rise_i) |=> tmr_q.state == HOLD_ACTIVE);

    // R4
    restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_i |=> (tmr_q.count == '0 && tmr_q.state == HOLD_ACTIVE));

    // R4
    hold_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmr_q.state == HOLD_ACTIVE && !rise_i && tmr_q.count != LAST)
        |=> (tmr_q.state == HOLD_ACTIVE && tmr_q.count == $past(tmr_q.count) + 1'b1));

    // R5
    expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmr_q.state == HOLD_ACTIVE && !rise_i && tmr_q.count == LAST)
        |=> tmr_q.state == HOLD_IDLE);

    // R6
    last_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmr_q.state == HOLD_ACTIVE && rise_i && tmr_q.count == LAST)
        |=> tmr_q.state == HOLD_ACTIVE);

    // R7
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmr_q.count <= LAST);

endmodule

// File: rtl/pulse_activity_hold.sv
module pulse_activity_hold
    import pah_pkg::*;
#(
    parameter longint unsigned CLK_HZ         = 1_000_000,
    parameter int unsigned     TIMEOUT_CYCLES = 500,
    parameter int unsigned     SYNC_STAGES    = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pulse_i,
    output logic active_o
);

    localparam longint unsigned FLOOR_CYCLES = us_to_cycles(CLK_HZ, MIN_SILENCE_US);
    localparam longint unsigned CEIL_CYCLES  = CLK_HZ;
    localparam longint unsigned ARM_BUDGET   = us_to_cycles(CLK_HZ, MAX_ARM_US);
    localparam longint unsigned ARM_LATENCY  = SYNC_STAGES + 1;

    if (longint'(TIMEOUT_CYCLES) <= FLOOR_CYCLES ||
        longint'(TIMEOUT_CYCLES) >= CEIL_CYCLES) begin : g_bad_window
        $error("silence window outside the allowed span");
    end
    if (ARM_LATENCY > ARM_BUDGET) begin : g_bad_latency
        $error("arming latency exceeds 80 us at this clock rate");
    end
    if (SYNC_STAGES < 2) begin : g_bad_sync
        $error("synchronizer needs at least two stages");
    end

    logic pulse_sync;
    logic pulse_rise;

    pah_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pulse_i),
        .sync_o  (pulse_sync)
    );

    pah_edge u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (pulse_sync),
        .rise_o  (pulse_rise)
    );

    pah_silence_timer #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rise_i (pulse_rise),
        .hold_o (active_o)
    );

endmodule

// File: tb/pulse_activity_hold_bench.sv
module pulse_activity_hold_bench;

    localparam time         CLK_PERIOD = 10ns;
    localparam int unsigned T          = 500;
    localparam int unsigned PERIOD     = 167;
    localparam int unsigned WIDTH      = 7;
    localparam int unsigned TRAIN_LEN  = 500;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic pulse_i = 1'b0;
    logic active_o;

    int unsigned cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int unsigned cyc;
        logic        val;
        string       req;
    } exp_t;

    exp_t sb_q[$];

    pulse_activity_hold #(
        .CLK_HZ         (1_000_000),
        .TIMEOUT_CYCLES (T),
        .SYNC_STAGES    (2)
    ) u_pulse_activity_hold (
        .clk_i    (clk),
        .rst_ni   (rst_ni),
        .pulse_i  (pulse_i),
        .active_o (active_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic expect_at(input int unsigned c, input logic v, input string req);
        exp_t e;
        e.cyc = c;
        e.val = v;
        e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic check_now(input logic v, input string req);
        checks++;
        if (active_o !== v) begin
            errors++;
            $display("FAIL %s cycle %0d: active_o=%b expected %b", req, cyc, active_o, v);
        end
    endtask

    // scoreboard monitor: compares every due expectation away from the active edge
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].cyc == cyc) begin
                check_now(sb_q[i].val, sb_q[i].req);
                sb_q.delete(i);
            end
        end
    end

    task automatic fire_at(input int unsigned target, input int unsigned width);
        @(negedge clk);
        while (cyc < target) @(negedge clk);
        pulse_i = 1'b1;
        repeat (width) @(negedge clk);
        pulse_i = 1'b0;
    endtask

    task automatic settle(input int unsigned n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int unsigned c;
        int unsigned tail;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_now(1'b0, "R1 during reset");
        rst_ni = 1'b1;
        settle(1);
        expect_at(cyc + 5, 1'b0, "R1 idle after reset");
        expect_at(cyc + 40, 1'b0, "R1 idle after reset");
        settle(50);

        // R2 / R5: single pulse
        c = cyc + 1;
        expect_at(c + 2, 1'b0, "R2 not yet armed");
        expect_at(c + 3, 1'b1, "R2 armed");
        expect_at(c + 2 + T, 1'b1, "R5 last high cycle");
        expect_at(c + 3 + T, 1'b0, "R5 cleared");
        fire_at(c, WIDTH);
        settle(T + 20);

        // R4: retrigger inside the window
        c = cyc + 1;
        expect_at(c + 3 + T, 1'b1, "R4 extended past first window");
        expect_at(c + 202 + T, 1'b1, "R4 last high cycle");
        expect_at(c + 203 + T, 1'b0, "R4 cleared after restart");
        fire_at(c, WIDTH);
        fire_at(c + 200, WIDTH);
        settle(T + 20);

        // R3: level held high beyond the window
        c = cyc + 1;
        expect_at(c + 3, 1'b1, "R3 armed");
        expect_at(c + 3 + T, 1'b0, "R3 cleared while input high");
        expect_at(c + 2 * T + 15, 1'b0, "R3 falling edge ignored");
        fire_at(c, 2 * T);
        settle(30);

        // R6: new edge registered exactly on the expiry edge
        c = cyc + 1;
        expect_at(c + 2 + T, 1'b1, "R6 before expiry");
        expect_at(c + 3 + T, 1'b1, "R6 new edge wins");
        expect_at(c + 2 + 2 * T, 1'b1, "R6 new window last cycle");
        expect_at(c + 3 + 2 * T, 1'b0, "R6 new window cleared");
        fire_at(c, WIDTH);
        fire_at(c + T, WIDTH);
        settle(T + 20);

        // R8: edge one cycle after the clear
        c = cyc + 1;
        expect_at(c + 3 + T, 1'b0, "R8 cleared");
        expect_at(c + 4 + T, 1'b1, "R8 re-armed");
        expect_at(c + 4 + 2 * T, 1'b0, "R8 second window cleared");
        fire_at(c, WIDTH);
        fire_at(c + T + 1, WIDTH);
        settle(T + 20);

        // R7: long train keeps the output high
        c = cyc + 1;
        for (int k = 0; k < TRAIN_LEN; k++) begin
            if (k > 0) expect_at(c + k * PERIOD + 2, 1'b1, "R7 still high in train");
            fire_at(c + k * PERIOD, WIDTH);
        end
        tail = c + (TRAIN_LEN - 1) * PERIOD;
        expect_at(tail + 2 + T, 1'b1, "R7 last high after train");
        expect_at(tail + 3 + T, 1'b0, "R7 cleared after train");
        settle(T + 20);

        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", sb_q.size());
        end
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

endmodule